// File: doc/BRIEF.md
# Serial ADC Sampling Master

This block drives a 12-bit successive-approximation converter with a three-wire serial link: an active-low chip select, a serial clock that idles high, and one data line coming back from the converter. While sampling is enabled it runs conversion frames back to back. Each frame lowers chip select, which starts the conversion. It then clocks in one 16-bit word and extracts the 12-bit code from it. The code appears at the output with a single-cycle valid strobe.

The converter sends two leading zeros, twelve data bits MSB first and then trailing zeros. It presents a new bit after each falling clock edge. In phase mode 0 the master latches on falling edges and the code sits in word bits [13:2]. In phase mode 1 the master latches on rising edges, so the stream appears one place earlier and the code sits in word bits [14:3]. A power-down request replaces the next frame with a short 8-clock frame. That frame raises chip select early, inside the window that tells the converter to sleep. A short frame yields no result.

Top module: `adc_spi_sampler`

## Requirements
- R1: While reset is asserted and after it is released, until a frame starts, `cs_no` and `sclk_o` are high and `result_valid_o` is low.
- R2: `sclk_o` is high whenever `cs_no` is high. Every frame starts and ends with the clock high.
- R3: With `cpha_i`=0 at frame start, `sdi_i` is latched on each falling `sclk_o` edge, first bit in the word MSB. The result is word bits [13:2].
- R4: With `cpha_i`=1 at frame start, `sdi_i` is latched on each rising `sclk_o` edge, first bit in the word MSB. The result is word bits [14:3].
- R5: Every transition of `cs_no` or `sclk_o` inside a frame is spaced exactly `div_i`+1 system cycles from the previous one. This includes chip-select fall to the first clock fall, and the last clock rise to chip-select rise.
- R6: Between two frames `cs_no` stays high for at least 2×(`div_i`+1) system cycles, using the divider of the frame that just ended.
- R7: A normal frame has exactly 16 falling and 16 rising clock edges.
- R8: A one-cycle pulse on `pd_req_i` makes a later frame a power-down frame. That frame has 8 falling and 8 rising edges. Chip select rises after the 8th falling edge and before a 9th, inside the converter's 2nd-to-10th falling-edge window. No result is produced.
- R9: `result_valid_o` is high for one cycle only. It is high in the cycle in which `cs_no` rises at the end of a normal frame.
- R10: Changes on `div_i` and `cpha_i` during a frame have no effect on that frame. The values present at chip-select fall apply to the whole frame.
- R11: Frames repeat while `enable_i` is high. A pending power-down request takes the next frame boundary, so at most one normal frame completes between the request and the power-down frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Run conversion frames continuously |
| cpha_i | input | 1 | Phase mode: 0 latch on falling edge, 1 latch on rising edge |
| div_i | input | 4 | Half-period of the serial clock minus one, in system cycles |
| pd_req_i | input | 1 | One-cycle request for a power-down frame |
| sdi_i | input | 1 | Serial data from the converter |
| cs_no | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock, idles high |
| result_o | output | 12 | Last 12-bit conversion code |
| result_valid_o | output | 1 | One-cycle strobe for a new code |

## Verification
The assertions assume that `sdi_i` is stable around every latching clock edge. This holds when the converter updates its bit a short delay after a falling clock edge and the half-period is at least one system cycle. They also assume that `pd_req_i` is a single-cycle pulse. The bench models the converter with a one-nanosecond output delay after each falling clock edge. It drives all inputs one nanosecond after the rising system edge. It changes `div_i` and `cpha_i` at random points, including mid-frame. It issues power-down pulses only as single cycles, with or without sampling enabled.

// File: rtl/adc_spi_pkg.sv
package adc_spi_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_GAP  = 2'd2
  } frame_state_e;
endpackage

// File: rtl/adc_sclk_div.sv
module adc_sclk_div #(
  parameter int unsigned DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i || tick_o)   cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end

  // divider count never passes the latched limit
  assert_cnt_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q <= div_i));
endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
  import adc_spi_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned PD_W   = 8,
  parameter int unsigned DIV_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             pd_req_i,
  input  logic             cpha_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             tick_i,
  output logic             run_o,
  output logic             cs_no,
  output logic             sclk_o,
  output logic             sample_o,
  output logic             frame_end_o,
  output logic             cpha_o,
  output logic [DIV_W-1:0] div_o
);
  localparam int unsigned PH_MAX = 2 * WORD_W + 3;
  localparam int unsigned PH_W   = $clog2(PH_MAX + 1);

  frame_state_e     state_q;
  logic [PH_W-1:0]  ph_q, ph_nxt, lim, gap_end;
  logic             cs_q, sclk_q, cpha_q, pd_q, pd_pend_q;
  logic [DIV_W-1:0] div_q;
  logic             start_ok, take;

  assign lim      = pd_q ? PH_W'(2 * PD_W) : PH_W'(2 * WORD_W);
  assign gap_end  = lim + PH_W'(3);
  assign ph_nxt   = ph_q + 1'b1;
  assign start_ok = enable_i | pd_pend_q;
  assign take     = start_ok && ((state_q == ST_IDLE) ||
                    (state_q == ST_GAP && tick_i && ph_nxt == gap_end));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cs_q      <= 1'b1;
      sclk_q    <= 1'b1;
      ph_q      <= '0;
      div_q     <= '0;
      cpha_q    <= 1'b0;
      pd_q      <= 1'b0;
      pd_pend_q <= 1'b0;
    end else begin
      if (take)          pd_pend_q <= pd_req_i;
      else if (pd_req_i) pd_pend_q <= 1'b1;
      if (take) begin
        state_q <= ST_XFER;
        cs_q    <= 1'b0;
        sclk_q  <= 1'b1;
        ph_q    <= '0;
        div_q   <= div_i;
        cpha_q  <= cpha_i;
        pd_q    <= pd_pend_q;
      end else begin
        case (state_q)
          ST_XFER: if (tick_i) begin
            ph_q <= ph_nxt;
            if (ph_q < lim) sclk_q <= ~sclk_q;
            else begin
              cs_q    <= 1'b1;
              state_q <= ST_GAP;
            end
          end
          ST_GAP: if (tick_i) begin
            ph_q <= ph_nxt;
            if (ph_nxt == gap_end) state_q <= ST_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  // latch on the edge the mode selects: falling for 0, rising for 1
  assign sample_o    = (state_q == ST_XFER) && tick_i && (ph_q < lim) && (sclk_q ^ cpha_q);
  assign frame_end_o = (state_q == ST_XFER) && tick_i && (ph_q == lim) && !pd_q;
  assign run_o       = (state_q != ST_IDLE);
  assign cs_no       = cs_q;
  assign sclk_o      = sclk_q;
  assign cpha_o      = cpha_q;
  assign div_o       = div_q;

  assert_sclk_idle_high_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_q |-> sclk_q);
  assert_sclk_on_tick_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sclk_q) |-> $past(tick_i));
  assert_ph_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_q <= PH_W'(PH_MAX));
  assert_cfg_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_XFER && $past(state_q) == ST_XFER) |-> ($stable(div_q) && $stable(cpha_q)));
  assert_pd_short_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_q && state_q == ST_XFER) |-> (ph_q <= PH_W'(2 * PD_W)));
endmodule

// File: rtl/adc_shift_rx.sv
module adc_shift_rx #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned RES_W  = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_i,
  input  logic             sdi_i,
  input  logic             cpha_i,
  output logic [RES_W-1:0] res_o
);
  localparam int unsigned SH0 = WORD_W - RES_W - 2;
  localparam int unsigned SH1 = SH0 + 1;

  logic [WORD_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (shift_i) sr_q <= {sr_q[WORD_W-2:0], sdi_i};
  end

  // rising-edge latching sees the stream one bit earlier
  assign res_o = cpha_i ? RES_W'(sr_q >> SH1) : RES_W'(sr_q >> SH0);
endmodule

// File: rtl/adc_spi_sampler.sv
module adc_spi_sampler #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned RES_W  = 12,
  parameter int unsigned PD_W   = 8,
  parameter int unsigned DIV_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             cpha_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             pd_req_i,
  input  logic             sdi_i,
  output logic             cs_no,
  output logic             sclk_o,
  output logic [RES_W-1:0] result_o,
  output logic             result_valid_o
);
  logic             tick, run, sample, frame_end, cpha_q;
  logic [DIV_W-1:0] div_q;
  logic [RES_W-1:0] res_w, result_q;
  logic             valid_q;

  adc_frame_ctrl #(.WORD_W(WORD_W), .PD_W(PD_W), .DIV_W(DIV_W)) i_ctrl (
    .clk_i, .rst_ni, .enable_i, .pd_req_i, .cpha_i, .div_i,
    .tick_i(tick), .run_o(run), .cs_no, .sclk_o,
    .sample_o(sample), .frame_end_o(frame_end), .cpha_o(cpha_q), .div_o(div_q)
  );

  adc_sclk_div #(.DIV_W(DIV_W)) i_div (
    .clk_i, .rst_ni, .run_i(run), .div_i(div_q), .tick_o(tick)
  );

  adc_shift_rx #(.WORD_W(WORD_W), .RES_W(RES_W)) i_rx (
    .clk_i, .rst_ni, .shift_i(sample), .sdi_i, .cpha_i(cpha_q), .res_o(res_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= frame_end;
      if (frame_end) result_q <= res_w;
    end
  end

  assign result_o       = result_q;
  assign result_valid_o = valid_q;

  assert_valid_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);
  assert_valid_at_cs_rise_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> $rose(cs_no));
  assert_reset_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> (cs_no && sclk_o));
endmodule

// File: tb/test_adc_spi_sampler.sv
`timescale 1ns/1ps
module test_adc_spi_sampler;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        enable_i = 1'b0;
  logic        cpha_i = 1'b0;
  logic [3:0]  div_i = 4'd0;
  logic        pd_req_i = 1'b0;
  logic        sdi_i = 1'b0;
  logic        cs_no, sclk_o, result_valid_o;
  logic [11:0] result_o;

  always #2.5 clk_i = ~clk_i;

  adc_spi_sampler i_adc_spi_sampler (
    .clk_i, .rst_ni, .enable_i, .cpha_i, .div_i, .pd_req_i, .sdi_i,
    .cs_no, .sclk_o, .result_o, .result_valid_o
  );

  int checks = 0;
  int errors = 0;
  int full_frames = 0;
  int pd_frames = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic stream_bit(input logic [11:0] d, input int i);
    return (i >= 2 && i <= 13) ? d[13-i] : 1'b0;
  endfunction

  // converter model: new bit 1 ns after each falling clock edge
  logic [11:0] cur_data = '0;
  int          bit_idx = 0;
  always @(negedge cs_no) begin
    cur_data = 12'($urandom);
    bit_idx  = 0;
    sdi_i    = 1'b0;
  end
  always @(negedge sclk_o) begin
    if (!cs_no) begin
      bit_idx++;
      #1 sdi_i = stream_bit(cur_data, bit_idx);
    end
  end

  // monitor
  int   cyc = 0, last_evt = 0, h = 1, falls = 0, rises = 0;
  bit   have_end = 0, finishing = 0;
  logic prev_cs = 1'b1, prev_sclk = 1'b1, last_cpha = 1'b0, f_cpha = 1'b0;
  logic [3:0] last_div = '0;

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(negedge clk_i) begin
    cyc++;
    if (cyc > 190000 && !finishing) begin
      finishing = 1;
      chk(1'b0, "watchdog", cyc, 190000);
      finish_run();
    end
    if (rst_ni) begin
      if (prev_cs && !cs_no) begin
        if (have_end) chk((cyc - last_evt) >= 2 * h, "R6 cs gap", cyc - last_evt, 2 * h);
        chk(sclk_o == 1'b1, "R2 sclk high at frame start", sclk_o, 1);
        h = int'(last_div) + 1;
        f_cpha = last_cpha;
        falls = 0; rises = 0; last_evt = cyc;
      end else if (!cs_no && sclk_o != prev_sclk) begin
        chk((cyc - last_evt) == h, "R5/R10 half period", cyc - last_evt, h);
        last_evt = cyc;
        if (!sclk_o) falls++; else rises++;
      end else if (!prev_cs && cs_no) begin
        chk((cyc - last_evt) == h, "R5 last rise to cs rise", cyc - last_evt, h);
        chk(sclk_o == 1'b1, "R2 sclk high at frame end", sclk_o, 1);
        last_evt = cyc; have_end = 1;
        if (rises == 16) begin
          full_frames++;
          chk(falls == 16, "R7 falling edges", falls, 16);
          chk(result_valid_o == 1'b1, "R9 valid at cs rise", result_valid_o, 1);
          if (f_cpha) chk(result_o == cur_data, "R4 phase1 result", result_o, cur_data);
          else        chk(result_o == cur_data, "R3 phase0 result", result_o, cur_data);
        end else if (rises == 8) begin
          pd_frames++;
          // cs rises after falling edge 8: inside the 2..10 window
          chk(falls == 8, "R8 power-down falling edges", falls, 8);
          chk(result_valid_o == 1'b0, "R8 no result on power-down", result_valid_o, 0);
        end else begin
          chk(1'b0, "R7 word length", rises, 16);
        end
      end else begin
        if (result_valid_o) chk(1'b0, "R9 stray valid", 1, 0);
        if (cs_no && !sclk_o) chk(1'b0, "R2 sclk low while idle", 0, 1);
      end
    end
    prev_cs = cs_no; prev_sclk = sclk_o;
    last_div = div_i; last_cpha = cpha_i;
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic pulse_pd();
    int n0, f0, t;
    n0 = pd_frames; f0 = full_frames;
    pd_req_i = 1'b1; step(1); pd_req_i = 1'b0;
    t = 0;
    while (pd_frames == n0 && t < 3000) begin step(1); t++; end
    chk(pd_frames > n0, "R8 power-down frame issued", pd_frames - n0, 1);
    chk((full_frames - f0) <= 1, "R11 power-down takes next boundary", full_frames - f0, 1);
  endtask

  initial begin
    void'($urandom(32'h5eed_0246));
    step(5);
    @(negedge clk_i);
    chk(cs_no == 1'b1, "R1 cs in reset", cs_no, 1);
    chk(sclk_o == 1'b1, "R1 sclk in reset", sclk_o, 1);
    chk(result_valid_o == 1'b0, "R1 valid in reset", result_valid_o, 0);
    step(1); rst_ni = 1'b1;
    step(20);
    chk(cs_no == 1'b1 && sclk_o == 1'b1, "R1 idle after reset", {cs_no, sclk_o}, 3);

    // directed: phase 0 fastest clock, then phase 1 slower
    cpha_i = 1'b0; div_i = 4'd0; enable_i = 1'b1;
    step(300);
    chk(full_frames >= 3, "R11 back-to-back frames", full_frames, 3);
    pulse_pd();
    cpha_i = 1'b1; div_i = 4'd3;
    step(800);
    pulse_pd();
    div_i = 4'd15; step(1500);

    // power-down from idle
    enable_i = 1'b0; step(700);
    pulse_pd();
    step(100);

    // random segments with mid-frame config changes (R10)
    for (int s = 0; s < 16; s++) begin
      enable_i = 1'b1;
      for (int k = 0; k < 6; k++) begin
        div_i  = 4'($urandom % 8);
        cpha_i = 1'($urandom);
        step(40 + ($urandom % 160));
      end
      if (($urandom % 3) == 0) pulse_pd();
      if (($urandom % 4) == 0) begin enable_i = 1'b0; step(700); end
    end

    enable_i = 1'b0; step(800);
    chk(cs_no == 1'b1 && sclk_o == 1'b1, "R2 idle after disable", {cs_no, sclk_o}, 3);
    chk(full_frames > 20, "R11 frame count", full_frames, 20);
    finishing = 1;
    finish_run();
  end
endmodule